// File: doc/BRIEF.md
# Display Command Interpreter

This block sits behind a serial-bus target front end and turns its received byte stream into frame-memory writes and display settings. The front end hands over one byte per `byte_valid` strobe and signals the close of a bus transaction with `xfer_end`. The first byte of a transaction is a control byte. It puts the interpreter into either data mode or command mode, and that mode holds for the bytes that follow.

In data mode, bytes are written through a registered write port into a page-organised monochrome frame memory. Each page row is `NUM_COLS` bytes wide. In command mode, single-byte opcodes move the column and page pointers and set or clear four display flags. A fixed set of opcodes carries one trailing parameter byte, and the interpreter consumes that byte without acting on it. A sticky redraw flag tells the scan-out side that the frame memory has changed.

Top module: `panel_cmd_decoder`

## Requirements
- R1: After synchronous reset, the column and page pointers, all four flags, redraw, `fb_we`, `unknown_cmd` and `ctrl_err` are 0. The block is idle with no parameter skip pending.
- R2: In idle mode, byte 0x80 selects command mode and byte 0x40 selects data mode. Any other byte gives a one-cycle `ctrl_err` pulse in the next cycle, and the block stays idle.
- R3: In data mode, a byte received while column < 132 gives `fb_we`=1 in the next cycle. In that cycle `fb_addr` = column + page*132 and `fb_wdata` is the byte. The column then advances by one.
- R4: In data mode, a byte received while column >= 132 is dropped. There is no write and the column is unchanged.
- R5: Opcodes 0x00..0x0F set column bits [3:0] to the opcode's bits [3:0]. Opcodes 0x10..0x20 set column bits [7:4] to the opcode's bits [3:0].
- R6: Opcodes 0xB0..0xBF set the page pointer to the opcode's bits [2:0].
- R7: Opcode bit 0 gives the new flag value for these pairs: 0xA0/0xA1 set mirror, 0xA4/0xA5 set all-on, 0xA6/0xA7 set inverse, and 0xAE/0xAF set enable.
- R8: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte received in command mode is discarded: no state changes and no `unknown_cmd` is raised. The block stays in command mode after that byte.
- R9: After any opcode is decoded (a skipped byte is not an opcode), the block is idle, so the next byte is read as a control byte.
- R10: Opcodes 0x40..0x7F, 0xC0..0xC8 and 0xE3 change no pointer or flag and raise no `unknown_cmd`.
- R11: Any other opcode gives a one-cycle `unknown_cmd` pulse in the next cycle and changes no pointer or flag.
- R12: `xfer_end` returns the block to idle from any mode, and a pending skip is kept. A byte that arrives in the same cycle is processed first.
- R13: `redraw` is set by every frame write and stays set until `clear_redraw`. If a write and `clear_redraw` coincide, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| xfer_end | input | 1 | End of the current bus transaction |
| clear_redraw | input | 1 | Scan-out acknowledges the redraw flag |
| fb_we | output | 1 | Frame memory write enable |
| fb_addr | output | ADDR_W (11) | Frame memory byte address |
| fb_wdata | output | 8 | Frame memory write data |
| column | output | 8 | Column pointer |
| page | output | PAGE_W (3) | Page pointer |
| flag_mirror | output | 1 | Horizontal mirror flag |
| flag_all_on | output | 1 | Force all pixels on |
| flag_inverse | output | 1 | Inverse video flag |
| flag_enable | output | 1 | Display enable flag |
| redraw | output | 1 | Frame memory changed since the last clear |
| unknown_cmd | output | 1 | One-cycle pulse for an unrecognised opcode |
| ctrl_err | output | 1 | One-cycle pulse for a bad control byte |

## Verification
Every result of a byte is registered. The write port, the two error pulses, the pointers, the flags and redraw therefore all show the effect of a byte in the cycle after the edge that accepted it, and the pulses last only that one cycle. The bench drives each byte for exactly one clock, starting on a falling edge, and compares all outputs on the next falling edge, which lands inside that single result cycle. A reference model in the bench advances by one byte, end event or clear at a time. Mode is not visible at the ports, so it is checked through its effect: each control byte that follows a command or an end event must be treated as a control byte.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_CMD  = 2'd1,
        M_DATA = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        K_COL_LO,
        K_COL_HI,
        K_PAGE,
        K_FLAG,
        K_SKIP,
        K_NOP,
        K_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        F_MIRROR,
        F_ALLON,
        F_INVERSE,
        F_ENABLE
    } flag_sel_e;

    typedef struct packed {
        op_kind_e  kind;
        flag_sel_e fsel;
        logic      fval;
        logic [3:0] arg;
    } op_info_t;

    typedef struct packed {
        logic mirror;
        logic all_on;
        logic inverse;
        logic enable;
    } flags_t;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

    // Sort one opcode into the action class it triggers.
    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t info;
        info.kind = K_BAD;
        info.fsel = F_MIRROR;
        info.fval = op[0];
        info.arg  = op[3:0];
        case (op) inside
            [8'h00:8'h0F]: info.kind = K_COL_LO;
            [8'h10:8'h20]: info.kind = K_COL_HI;
            [8'hB0:8'hBF]: info.kind = K_PAGE;
            8'hA0, 8'hA1: begin info.kind = K_FLAG; info.fsel = F_MIRROR;  end
            8'hA4, 8'hA5: begin info.kind = K_FLAG; info.fsel = F_ALLON;   end
            8'hA6, 8'hA7: begin info.kind = K_FLAG; info.fsel = F_INVERSE; end
            8'hAE, 8'hAF: begin info.kind = K_FLAG; info.fsel = F_ENABLE;  end
            8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
            8'hD8, 8'hD9, 8'hDA, 8'hDB: info.kind = K_SKIP;
            [8'h40:8'h7F], [8'hC0:8'hC8], 8'hE3: info.kind = K_NOP;
            default: info.kind = K_BAD;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/panel_op_classify.sv
module panel_op_classify
    import panel_cmd_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    assign info = classify(op);
endmodule

// File: rtl/panel_state_regs.sv
module panel_state_regs
    import panel_cmd_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_apply,
    input  op_info_t          info,
    input  logic              col_inc,
    output logic [COL_W-1:0]  column,
    output logic [PAGE_W-1:0] page,
    output flags_t            flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            column <= '0;
            page   <= '0;
            flags  <= '0;
        end else if (col_inc) begin
            column <= column + COL_W'(1);
        end else if (cmd_apply) begin
            case (info.kind)
                K_COL_LO: column[3:0] <= info.arg;
                K_COL_HI: column[7:4] <= info.arg;
                K_PAGE:   page        <= info.arg[PAGE_W-1:0];
                K_FLAG: begin
                    case (info.fsel)
                        F_MIRROR:  flags.mirror  <= info.fval;
                        F_ALLON:   flags.all_on  <= info.fval;
                        F_INVERSE: flags.inverse <= info.fval;
                        default:   flags.enable  <= info.fval;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Unknown and no-effect opcodes leave pointers and flags alone.
    p_bad_op_still_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_apply && !col_inc && info.kind == K_BAD)
        |=> ($stable(column) && $stable(page) && $stable(flags)));

    p_nop_still_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_apply && !col_inc && info.kind == K_NOP)
        |=> ($stable(column) && $stable(page) && $stable(flags)));
endmodule

// File: rtl/panel_cmd_decoder.sv
module panel_cmd_decoder
    import panel_cmd_pkg::*;
#(
    parameter int NUM_COLS  = 132,
    parameter int NUM_PAGES = 8,
    localparam int FB_DEPTH = NUM_COLS * NUM_PAGES,
    localparam int ADDR_W   = $clog2(FB_DEPTH),
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              xfer_end,
    input  logic              clear_redraw,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        fb_wdata,
    output logic [7:0]        column,
    output logic [PAGE_W-1:0] page,
    output logic              flag_mirror,
    output logic              flag_all_on,
    output logic              flag_inverse,
    output logic              flag_enable,
    output logic              redraw,
    output logic              unknown_cmd,
    output logic              ctrl_err
);
    localparam int COL_W = 8;
    localparam logic [ADDR_W-1:0] COLS_A = ADDR_W'(NUM_COLS);

    mode_e    mode_q, mode_d;
    logic     skip_q;
    op_info_t info;
    flags_t   flags;

    panel_op_classify u_classify (
        .op   (byte_data),
        .info (info)
    );

    logic in_cmd, skip_byte, cmd_apply, col_ok, col_inc;
    assign in_cmd    = byte_valid && (mode_q == M_CMD);
    assign skip_byte = in_cmd && skip_q;
    assign cmd_apply = in_cmd && !skip_q;
    assign col_ok    = column < COL_W'(NUM_COLS);
    assign col_inc   = byte_valid && (mode_q == M_DATA) && col_ok;

    panel_state_regs #(
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_apply (cmd_apply),
        .info      (info),
        .col_inc   (col_inc),
        .column    (column),
        .page      (page),
        .flags     (flags)
    );

    assign flag_mirror  = flags.mirror;
    assign flag_all_on  = flags.all_on;
    assign flag_inverse = flags.inverse;
    assign flag_enable  = flags.enable;

    always_comb begin
        mode_d = mode_q;
        if (byte_valid) begin
            case (mode_q)
                M_IDLE: begin
                    if (byte_data == CTRL_CMD)       mode_d = M_CMD;
                    else if (byte_data == CTRL_DATA) mode_d = M_DATA;
                end
                M_CMD:   if (!skip_q) mode_d = M_IDLE;
                default: mode_d = mode_q;
            endcase
        end
        if (xfer_end) mode_d = M_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= M_IDLE;
            skip_q      <= 1'b0;
            fb_we       <= 1'b0;
            fb_addr     <= '0;
            fb_wdata    <= '0;
            redraw      <= 1'b0;
            unknown_cmd <= 1'b0;
            ctrl_err    <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (skip_byte)      skip_q <= 1'b0;
            else if (cmd_apply) skip_q <= (info.kind == K_SKIP);
            fb_we    <= col_inc;
            fb_addr  <= ADDR_W'(column) + ADDR_W'(page) * COLS_A;
            fb_wdata <= byte_data;
            if (col_inc)           redraw <= 1'b1;
            else if (clear_redraw) redraw <= 1'b0;
            unknown_cmd <= cmd_apply && (info.kind == K_BAD);
            ctrl_err    <= byte_valid && (mode_q == M_IDLE)
                           && (byte_data != CTRL_CMD) && (byte_data != CTRL_DATA);
        end
    end

    p_ctrl_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_err |-> (mode_q == M_IDLE && !fb_we));

    p_write_advances_r3: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (column == COL_W'($past(column) + COL_W'(1))));

    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && mode_q == M_DATA && !col_ok) |=> (!fb_we && $stable(column)));

    p_skip_consumed_r8: assert property (@(posedge clk) disable iff (rst)
        (skip_byte && !xfer_end)
        |=> (mode_q == M_CMD && !skip_q && !unknown_cmd && $stable(column) && $stable(page)));

    p_cmd_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_apply |=> (mode_q == M_IDLE));

    p_end_idle_r12: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> (mode_q == M_IDLE));

    p_redraw_set_r13: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> redraw);

    p_pulses_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({fb_we, unknown_cmd, ctrl_err}) <= 1);
endmodule

// File: tb/sim_panel_cmd_decoder.sv
module sim_panel_cmd_decoder;
    logic clk = 0;
    logic rst = 1;
    logic byte_valid = 0;
    logic [7:0] byte_data = 0;
    logic xfer_end = 0;
    logic clear_redraw = 0;
    logic fb_we;
    logic [10:0] fb_addr;
    logic [7:0] fb_wdata;
    logic [7:0] column;
    logic [2:0] page;
    logic flag_mirror, flag_all_on, flag_inverse, flag_enable;
    logic redraw, unknown_cmd, ctrl_err;

    always #5 clk = ~clk;

    panel_cmd_decoder u0 (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .xfer_end(xfer_end), .clear_redraw(clear_redraw), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .column(column), .page(page),
        .flag_mirror(flag_mirror), .flag_all_on(flag_all_on),
        .flag_inverse(flag_inverse), .flag_enable(flag_enable),
        .redraw(redraw), .unknown_cmd(unknown_cmd), .ctrl_err(ctrl_err)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_mode = 0;              // 0 idle, 1 command, 2 data
    bit m_skip = 0;
    logic [7:0] m_col = 0;
    logic [2:0] m_page = 0;
    logic [3:0] m_flags = 0;     // {mirror, all_on, inverse, enable}
    bit m_red = 0;
    bit e_we, e_unk, e_err;
    logic [10:0] e_addr;
    logic [7:0] e_data;
    string m_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(fb_we === e_we, tag, "fb_we", 32'(fb_we), 32'(e_we));
        if (e_we) begin
            chk(fb_addr === e_addr, tag, "fb_addr", 32'(fb_addr), 32'(e_addr));
            chk(fb_wdata === e_data, tag, "fb_wdata", 32'(fb_wdata), 32'(e_data));
        end
        chk(unknown_cmd === e_unk, tag, "unknown_cmd", 32'(unknown_cmd), 32'(e_unk));
        chk(ctrl_err === e_err, tag, "ctrl_err", 32'(ctrl_err), 32'(e_err));
        chk(column === m_col, tag, "column", 32'(column), 32'(m_col));
        chk(page === m_page, tag, "page", 32'(page), 32'(m_page));
        chk({flag_mirror, flag_all_on, flag_inverse, flag_enable} === m_flags, tag, "flags",
            32'({flag_mirror, flag_all_on, flag_inverse, flag_enable}), 32'(m_flags));
        chk(redraw === m_red, tag, "redraw", 32'(redraw), 32'(m_red));
    endtask

    function automatic bit is_skip_op(input logic [7:0] b);
        return b inside {8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'hDB};
    endfunction

    function automatic bit is_nop_op(input logic [7:0] b);
        return (b >= 8'h40 && b <= 8'h7F) || (b >= 8'hC0 && b <= 8'hC8) || b == 8'hE3;
    endfunction

    task automatic model_byte(input logic [7:0] b);
        case (m_mode)
            0: begin
                m_tag = "R2";
                if (b == 8'h80) m_mode = 1;
                else if (b == 8'h40) m_mode = 2;
                else e_err = 1;
            end
            1: begin
                if (m_skip) begin
                    m_skip = 0;
                    m_tag = "R8";
                end else begin
                    m_mode = 0;
                    if (b <= 8'h0F) begin m_col[3:0] = b[3:0]; m_tag = "R5"; end
                    else if (b <= 8'h20) begin m_col[7:4] = b[3:0]; m_tag = "R5"; end
                    else if (b >= 8'hB0 && b <= 8'hBF) begin m_page = b[2:0]; m_tag = "R6"; end
                    else if (b == 8'hA0 || b == 8'hA1) begin m_flags[3] = b[0]; m_tag = "R7"; end
                    else if (b == 8'hA4 || b == 8'hA5) begin m_flags[2] = b[0]; m_tag = "R7"; end
                    else if (b == 8'hA6 || b == 8'hA7) begin m_flags[1] = b[0]; m_tag = "R7"; end
                    else if (b == 8'hAE || b == 8'hAF) begin m_flags[0] = b[0]; m_tag = "R7"; end
                    else if (is_skip_op(b)) begin m_skip = 1; m_tag = "R8"; end
                    else if (is_nop_op(b)) m_tag = "R10";
                    else begin e_unk = 1; m_tag = "R11"; end
                end
            end
            default: begin
                if (m_col < 8'd132) begin
                    e_we = 1;
                    e_addr = 11'(m_col) + 11'(m_page) * 11'd132;
                    e_data = b;
                    m_col = m_col + 8'd1;
                    m_red = 1;
                    m_tag = "R3";
                end else m_tag = "R4";
            end
        endcase
    endtask

    // One clock of stimulus, then compare in the following cycle.
    task automatic drive(input logic [7:0] b, input bit v, input bit e, input bit c,
                         input string tag);
        @(negedge clk);
        byte_valid = v; byte_data = b; xfer_end = e; clear_redraw = c;
        e_we = 0; e_unk = 0; e_err = 0; m_tag = "R12";
        if (v) model_byte(b);
        if (e) m_mode = 0;
        if (c && !e_we) begin m_red = 0; m_tag = "R13"; end
        @(negedge clk);
        byte_valid = 0; xfer_end = 0; clear_redraw = 0;
        compare_all(tag == "" ? m_tag : tag);
    endtask

    task automatic send(input logic [7:0] b, input string tag = "");
        drive(b, 1, 0, 0, tag);
    endtask

    task automatic end_xfer();
        drive(8'h00, 0, 1, 0, "R12");
    endtask

    task automatic cmd(input logic [7:0] op, input string tag = "");
        send(8'h80, "R2");
        send(op, tag);
    endtask

    logic [7:0] pool [16] = '{8'h00, 8'h05, 8'h18, 8'h13, 8'hB3, 8'hB7, 8'hA1, 8'hA6,
                              8'hAF, 8'h81, 8'hDB, 8'h55, 8'hC8, 8'hE3, 8'hA2, 8'hFF};

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        e_we = 0; e_unk = 0; e_err = 0;
        compare_all("R1");

        // R2: bad control byte, then valid ones
        send(8'h12, "R2");
        send(8'h12, "R2");
        send(8'h40, "R2");
        // R3: writes from column 0, page 0
        send(8'hA5, "R3");
        send(8'h3C, "R3");
        end_xfer();
        // R12: data mode left, next byte is a control byte
        send(8'h77, "R12");
        // R6 / R5 pointers, R9 back to idle after each opcode
        cmd(8'hB2, "R6");
        send(8'h33, "R9");
        cmd(8'h05, "R5");
        cmd(8'h1F, "R5");
        cmd(8'h20, "R5");
        send(8'h40, "R9");
        send(8'hAA, "R3");
        end_xfer();
        // R4: column 131 accepted, 132 dropped
        cmd(8'h03, "R5");
        cmd(8'h18, "R5");
        send(8'h40);
        send(8'h11, "R3");
        send(8'h22, "R4");
        send(8'h33, "R4");
        end_xfer();
        // R7 flags
        cmd(8'hA1, "R7"); cmd(8'hA5, "R7"); cmd(8'hA7, "R7"); cmd(8'hAF, "R7");
        cmd(8'hA6, "R7"); cmd(8'hA0, "R7");
        // R8: parameter byte swallowed, command mode kept afterwards
        cmd(8'hAD, "R8");
        cmd(8'hAE, "R8");
        send(8'hA4, "R8");
        send(8'h42, "R9");
        end_xfer();
        // R8 with pending skip kept across an end event (R12)
        cmd(8'hD5, "R8");
        end_xfer();
        cmd(8'hFF, "R12");
        // R10 and R11
        cmd(8'h55, "R10"); cmd(8'hC3, "R10"); cmd(8'hE3, "R10");
        cmd(8'hA2, "R11"); cmd(8'hFF, "R11"); cmd(8'h90, "R11");
        // R12: byte and end in the same cycle
        send(8'h40);
        cmd(8'h00, "R5");
        cmd(8'hB0, "R6");
        send(8'h40);
        drive(8'h5A, 1, 1, 0, "R12");
        send(8'h99, "R12");
        // R13: clear, then clear with a coinciding write
        drive(8'h00, 0, 0, 1, "R13");
        send(8'h40);
        drive(8'h6B, 1, 0, 1, "R13");
        drive(8'h00, 0, 0, 1, "R13");
        end_xfer();

        // Random phase
        void'($urandom(32'h2C0FFEE));
        for (int t = 0; t < 300; t++) begin
            int r;
            int n;
            logic [7:0] ctl;
            end_xfer();
            r = $urandom;
            if (r % 8 == 0) ctl = 8'($urandom);
            else ctl = (r % 2) ? 8'h80 : 8'h40;
            send(ctl);
            n = 1 + ($urandom % 4);
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                if (($urandom % 4) == 0) b = 8'($urandom);
                else b = pool[$urandom % 16];
                drive(b, 1, 0, ($urandom % 8) == 0, "");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule